// File: doc/BRIEF.md
# Dual-Issue Register Rename Table

This block maps architectural registers to physical tags for two instructions per clock. It keeps one table entry per architectural register, and each entry holds the physical tag currently bound to that register. On every accepted group, both instructions have their source registers translated to physical tags and receive fresh destination tags. The table is then updated so that later groups read the new bindings.

The two lanes are ordered. Lane A is the older instruction and lane B the younger. Lane B sees lane A's new binding in the same cycle, so a read-after-write between the lanes stays correct. A write-after-write between the lanes leaves the younger binding in the table.

Fresh tags come from an internal allocation head that advances by the number of destinations consumed. An external count of free tags gates the whole group. If the count is too small, the group stalls. A flush restores the identity mapping.

Top module: `rn_dual_rename`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid` is low. Afterwards entry r of the table maps to tag r for every architectural register r, and the first destination tag handed out is 32 (the architectural register count).
- R2: A group presented with `in_valid` high that is neither stalled nor flushed is accepted at the clock edge, and its results appear with `out_valid` high in the next cycle. In any cycle that follows no accepted group, `out_valid` is low.
- R3: Lane A's source tags are the table contents from before the group. This holds even when lane A's own destination is the same register as one of its sources. Lane B's sources also come from the table whenever lane A does not write them.
- R4: When lane A has a destination and a lane B source names the same architectural register, that lane B source receives lane A's new tag, not the table value.
- R5: Destination tags are issued in increasing order modulo 128. Lane A gets the current head. Lane B gets the head plus one if lane A has a destination, and the head itself if not. The head then advances by the number of destinations in the group, wrapping from 127 to 0.
- R6: An instruction whose destination-enable bit is 0 consumes no tag and writes no table entry. Its `*_dst_vld` output is 0 and its `*_dtag` output is 0.
- R7: After an accepted group, each enabled destination entry holds its new tag, and every other entry keeps its previous value. When both lanes name the same destination register, the entry holds lane B's tag.
- R8: `stall` is high exactly when `in_valid` is high and the number of enabled destinations in the group (0, 1 or 2) exceeds `free_cnt`. A stalled group produces no output and leaves both the table and the allocation head unchanged.
- R9: When `flush` is high at a clock edge, every entry returns to the identity mapping, any group presented in that cycle is discarded with no output, and the allocation head keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Restore identity mapping, drop current group |
| in_valid | input | 1 | A rename group is presented |
| free_cnt | input | 8 | Number of physical tags currently free |
| a_src0 | input | 5 | Lane A (older) first source register |
| a_src1 | input | 5 | Lane A second source register |
| a_dst | input | 5 | Lane A destination register |
| a_dst_en | input | 1 | Lane A has a destination |
| b_src0 | input | 5 | Lane B (younger) first source register |
| b_src1 | input | 5 | Lane B second source register |
| b_dst | input | 5 | Lane B destination register |
| b_dst_en | input | 1 | Lane B has a destination |
| stall | output | 1 | Group cannot be accepted this cycle |
| out_valid | output | 1 | Renamed results are valid |
| a_tag0 | output | 7 | Lane A first source tag |
| a_tag1 | output | 7 | Lane A second source tag |
| a_dtag | output | 7 | Lane A destination tag |
| a_dst_vld | output | 1 | Lane A destination tag is meaningful |
| b_tag0 | output | 7 | Lane B first source tag |
| b_tag1 | output | 7 | Lane B second source tag |
| b_dtag | output | 7 | Lane B destination tag |
| b_dst_vld | output | 1 | Lane B destination tag is meaningful |

## Verification
`stall` is combinational. It is due in the same cycle the group is driven, so it is sampled a moment after the inputs change, before the next rising edge. Renamed tags and `out_valid` pass through one register stage and are due in the cycle after the accepting edge. Each driven group therefore pushes exactly one expected item, and the monitor pops and compares it at the following falling edge. Table updates and flushes take effect at the same edge, so they are checked through the source tags of the very next group.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int ARCH_REGS = 32;
    localparam int PHYS_TAGS = 128;
    localparam int LANES     = 2;
    localparam int SRCS      = 2;
    localparam int AREG_W    = $clog2(ARCH_REGS);
    localparam int TAG_W     = $clog2(PHYS_TAGS);
    localparam int CNT_W     = $clog2(PHYS_TAGS + 1);
    localparam int RD_PORTS  = LANES * SRCS;

    typedef logic [AREG_W-1:0] areg_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // One decoded instruction entering rename
    typedef struct packed {
        areg_t src0;
        areg_t src1;
        areg_t dst;
        logic  dst_en;
    } rn_op_t;

    // One renamed instruction leaving rename
    typedef struct packed {
        tag_t tag0;
        tag_t tag1;
        tag_t dtag;
        logic dst_vld;
    } rn_res_t;

    // Tag bound to an architectural register after reset or flush
    function automatic tag_t home_tag(input int idx);
        return tag_t'(idx);
    endfunction

    // Override a table read with an older lane's fresh tag on a match
    function automatic tag_t fwd_pick(input areg_t src, input rn_op_t older,
                                      input tag_t older_tag, input tag_t tbl);
        return (older.dst_en && (older.dst == src)) ? older_tag : tbl;
    endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
#(
    parameter int N_RD = RD_PORTS,
    parameter int N_WR = LANES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  areg_t           rd_addr [N_RD],
    output tag_t            rd_tag  [N_RD],
    input  logic [N_WR-1:0] wr_en,
    input  areg_t           wr_addr [N_WR],
    input  tag_t            wr_tag  [N_WR]
);

    tag_t map_q [ARCH_REGS];

    // One register per architectural entry; higher write port is younger and wins
    for (genvar e = 0; e < ARCH_REGS; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                map_q[e] <= home_tag(e);
            end else begin
                for (int w = 0; w < N_WR; w++) begin
                    if (wr_en[w] && (wr_addr[w] == AREG_W'(e))) begin
                        map_q[e] <= wr_tag[w];
                    end
                end
            end
        end
    end

    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        assign rd_tag[r] = map_q[rd_addr[r]];
    end

endmodule

// File: rtl/rn_tag_alloc.sv
module rn_tag_alloc
    import rn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    input  cnt_t             free_cnt,
    input  logic [LANES-1:0] dst_en,
    output logic             stall,
    output logic             accept,
    output tag_t             lane_tag [LANES],
    output tag_t             head
);

    tag_t head_q;
    cnt_t need;

    always_comb begin
        need = '0;
        for (int l = 0; l < LANES; l++) begin
            need = need + CNT_W'(dst_en[l]);
        end
    end

    // Each lane takes the head plus the count of older lanes that allocate
    always_comb begin : p_lane_tags
        tag_t run;
        run = head_q;
        for (int l = 0; l < LANES; l++) begin
            lane_tag[l] = run;
            run = run + TAG_W'(dst_en[l]);
        end
    end

    assign stall  = in_valid && (need > free_cnt);
    assign accept = in_valid && !stall && !flush;
    assign head   = head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= TAG_W'(ARCH_REGS);
        end else if (accept) begin
            head_q <= head_q + TAG_W'(need);
        end
    end

endmodule

// File: rtl/rn_group_fwd.sv
module rn_group_fwd
    import rn_pkg::*;
(
    input  rn_op_t  op      [LANES],
    input  tag_t    tbl_tag [RD_PORTS],
    input  tag_t    new_tag [LANES],
    output rn_res_t res     [LANES]
);

    // Walk older lanes in age order so the youngest older writer wins
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin : p_fwd
            tag_t t0;
            tag_t t1;
            t0 = tbl_tag[l*SRCS];
            t1 = tbl_tag[l*SRCS + 1];
            for (int j = 0; j < l; j++) begin
                t0 = fwd_pick(op[l].src0, op[j], new_tag[j], t0);
                t1 = fwd_pick(op[l].src1, op[j], new_tag[j], t1);
            end
            res[l].tag0    = t0;
            res[l].tag1    = t1;
            res[l].dtag    = op[l].dst_en ? new_tag[l] : '0;
            res[l].dst_vld = op[l].dst_en;
        end
    end

endmodule

// File: rtl/rn_dual_rename.sv
module rn_dual_rename
    import rn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [CNT_W-1:0]  free_cnt,
    input  logic [AREG_W-1:0] a_src0,
    input  logic [AREG_W-1:0] a_src1,
    input  logic [AREG_W-1:0] a_dst,
    input  logic              a_dst_en,
    input  logic [AREG_W-1:0] b_src0,
    input  logic [AREG_W-1:0] b_src1,
    input  logic [AREG_W-1:0] b_dst,
    input  logic              b_dst_en,
    output logic              stall,
    output logic              out_valid,
    output logic [TAG_W-1:0]  a_tag0,
    output logic [TAG_W-1:0]  a_tag1,
    output logic [TAG_W-1:0]  a_dtag,
    output logic              a_dst_vld,
    output logic [TAG_W-1:0]  b_tag0,
    output logic [TAG_W-1:0]  b_tag1,
    output logic [TAG_W-1:0]  b_dtag,
    output logic              b_dst_vld
);

    rn_op_t           op       [LANES];
    areg_t            rd_addr  [RD_PORTS];
    tag_t             tbl_tag  [RD_PORTS];
    tag_t             new_tag  [LANES];
    areg_t            wr_addr  [LANES];
    logic [LANES-1:0] wr_en;
    logic [LANES-1:0] dst_en;
    rn_res_t          res      [LANES];
    rn_res_t          res_q    [LANES];
    logic             grp_acc;
    tag_t             alloc_head;
    logic             out_valid_q;

    assign op[0] = '{src0: a_src0, src1: a_src1, dst: a_dst, dst_en: a_dst_en};
    assign op[1] = '{src0: b_src0, src1: b_src1, dst: b_dst, dst_en: b_dst_en};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_addr[l*SRCS]     = op[l].src0;
        assign rd_addr[l*SRCS + 1] = op[l].src1;
        assign dst_en[l]           = op[l].dst_en;
        assign wr_en[l]            = grp_acc && op[l].dst_en;
        assign wr_addr[l]          = op[l].dst;
    end

    rn_tag_alloc u_alloc (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .in_valid (in_valid),
        .free_cnt (free_cnt),
        .dst_en   (dst_en),
        .stall    (stall),
        .accept   (grp_acc),
        .lane_tag (new_tag),
        .head     (alloc_head)
    );

    rn_map_table #(.N_RD(RD_PORTS), .N_WR(LANES)) u_table (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .rd_addr (rd_addr),
        .rd_tag  (tbl_tag),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_tag  (new_tag)
    );

    rn_group_fwd u_fwd (
        .op      (op),
        .tbl_tag (tbl_tag),
        .new_tag (new_tag),
        .res     (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= grp_acc;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_outq
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q[l] <= '0;
            end else if (grp_acc) begin
                res_q[l] <= res[l];
            end
        end
    end

    assign out_valid = out_valid_q;
    assign a_tag0    = res_q[0].tag0;
    assign a_tag1    = res_q[0].tag1;
    assign a_dtag    = res_q[0].dtag;
    assign a_dst_vld = res_q[0].dst_vld;
    assign b_tag0    = res_q[1].tag0;
    assign b_tag1    = res_q[1].tag1;
    assign b_dtag    = res_q[1].dtag;
    assign b_dst_vld = res_q[1].dst_vld;

endmodule

// File: rtl/rn_dual_rename_chk.sv
module rn_dual_rename_chk
    import rn_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic flush,
    input logic in_valid,
    input logic stall,
    input logic out_valid,
    input logic acc,
    input tag_t head,
    input tag_t a_dtag,
    input tag_t b_dtag,
    input logic a_dst_vld,
    input logic b_dst_vld
);

    // R1
    head_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (head == TAG_W'(ARCH_REGS)));

    // R2
    valid_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R5
    tag_sequence_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && a_dst_vld && b_dst_vld) |-> (b_dtag == a_dtag + 1'b1));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(head));

    // R6
    no_dest_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !a_dst_vld) |-> (a_dtag == '0));

    // R8
    stall_source_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> in_valid);

    // R8
    stall_drop_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !out_valid);

    // R9
    flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);

endmodule

bind rn_dual_rename rn_dual_rename_chk i_rn_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .in_valid  (in_valid),
    .stall     (stall),
    .out_valid (out_valid),
    .acc       (grp_acc),
    .head      (alloc_head),
    .a_dtag    (a_dtag),
    .b_dtag    (b_dtag),
    .a_dst_vld (a_dst_vld),
    .b_dst_vld (b_dst_vld)
);

// File: tb/test_rn_dual_rename.sv
module test_rn_dual_rename;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;
    localparam int NTAG = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] free_cnt = 8'd128;
    logic [4:0] a_src0 = '0, a_src1 = '0, a_dst = '0;
    logic [4:0] b_src0 = '0, b_src1 = '0, b_dst = '0;
    logic       a_dst_en = 1'b0, b_dst_en = 1'b0;
    logic       stall, out_valid, a_dst_vld, b_dst_vld;
    logic [6:0] a_tag0, a_tag1, a_dtag, b_tag0, b_tag1, b_dtag;

    always #(CLK_PERIOD/2) clk = ~clk;

    rn_dual_rename i_rn_dual_rename (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .free_cnt(free_cnt),
        .a_src0(a_src0), .a_src1(a_src1), .a_dst(a_dst), .a_dst_en(a_dst_en),
        .b_src0(b_src0), .b_src1(b_src1), .b_dst(b_dst), .b_dst_en(b_dst_en),
        .stall(stall), .out_valid(out_valid),
        .a_tag0(a_tag0), .a_tag1(a_tag1), .a_dtag(a_dtag), .a_dst_vld(a_dst_vld),
        .b_tag0(b_tag0), .b_tag1(b_tag1), .b_dtag(b_dtag), .b_dst_vld(b_dst_vld)
    );

    typedef struct {
        bit v;
        int a0, a1, ad; bit av;
        int b0, b1, bd; bit bv;
        bit b0_fwd, b1_fwd;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    int    mt [NREG];
    int    nxt;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: compares one expected item per cycle, one cycle after it was driven
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_q.size() > 0) begin
                exp_t  e;
                string rq;
                e  = exp_q.pop_front();
                rq = req_q.pop_front();
                chk(out_valid == e.v, rq, "out_valid", int'(out_valid), int'(e.v));
                if (e.v && out_valid) begin
                    chk(a_tag0 == e.a0, "R3", "a_tag0", a_tag0, e.a0);
                    chk(a_tag1 == e.a1, "R3", "a_tag1", a_tag1, e.a1);
                    chk(b_tag0 == e.b0, e.b0_fwd ? "R4" : rq, "b_tag0", b_tag0, e.b0);
                    chk(b_tag1 == e.b1, e.b1_fwd ? "R4" : rq, "b_tag1", b_tag1, e.b1);
                    chk(a_dtag == e.ad, e.av ? "R5" : "R6", "a_dtag", a_dtag, e.ad);
                    chk(b_dtag == e.bd, e.bv ? "R5" : "R6", "b_dtag", b_dtag, e.bd);
                    chk(a_dst_vld == e.av, "R6", "a_dst_vld", a_dst_vld, e.av);
                    chk(b_dst_vld == e.bv, "R6", "b_dst_vld", b_dst_vld, e.bv);
                end
            end else begin
                chk(!out_valid, "R2", "unexpected out_valid", int'(out_valid), 0);
            end
        end
    end

    // Driver: presents one group and pushes its expected result
    task automatic grp(input bit v, input bit fl, input int fr,
                       input int as0, input int as1, input int ad, input bit ae,
                       input int bs0, input int bs1, input int bd, input bit be,
                       input string req);
        exp_t e;
        int   need;
        bit   est;
        @(negedge clk);
        in_valid = v; flush = fl; free_cnt = 8'(fr);
        a_src0 = 5'(as0); a_src1 = 5'(as1); a_dst = 5'(ad); a_dst_en = ae;
        b_src0 = 5'(bs0); b_src1 = 5'(bs1); b_dst = 5'(bd); b_dst_en = be;
        #1;
        need = int'(ae) + int'(be);
        est  = v && (need > fr);
        chk(stall == est, "R8", "stall", int'(stall), int'(est));
        e = '{default: 0};
        if (fl) begin
            for (int r = 0; r < NREG; r++) mt[r] = r;
        end else if (v && !est) begin
            e.v  = 1;
            e.a0 = mt[as0]; e.a1 = mt[as1];
            e.av = ae; e.bv = be;
            e.ad = ae ? nxt : 0;
            e.bd = be ? (nxt + int'(ae)) % NTAG : 0;
            e.b0_fwd = ae && (bs0 == ad);
            e.b1_fwd = ae && (bs1 == ad);
            e.b0 = e.b0_fwd ? e.ad : mt[bs0];
            e.b1 = e.b1_fwd ? e.ad : mt[bs1];
            if (ae) mt[ad] = e.ad;
            if (be) mt[bd] = e.bd;
            nxt = (nxt + need) % NTAG;
        end
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic idle(input string req);
        grp(0, 0, 128, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) mt[r] = r;
        nxt = NREG;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(!stall, "R1", "stall after reset", int'(stall), 0);

        // R1: identity mapping and first tag 32
        grp(1, 0, 128, 5, 6, 1, 1, 1, 7, 4, 1, "R1");
        // R4: younger reads both sources from older destination
        grp(1, 0, 128, 8, 9, 2, 1, 2, 2, 3, 1, "R4");
        // R3: older source equal to own destination reads the old binding
        grp(1, 0, 128, 1, 1, 1, 1, 4, 9, 9, 1, "R3");
        // R7: both lanes write register 10, then the table holds the younger tag
        grp(1, 0, 128, 3, 4, 10, 1, 5, 6, 10, 1, "R7");
        grp(1, 0, 128, 10, 20, 0, 0, 10, 21, 0, 0, "R7");
        // R6: older without destination does not forward and takes no tag
        grp(1, 0, 128, 12, 13, 12, 0, 12, 1, 11, 1, "R6");
        grp(1, 0, 128, 11, 12, 14, 0, 0, 0, 0, 0, "R6");
        // R8: too few free tags, then exact fit, then zero need with zero free
        grp(1, 0, 1, 1, 2, 13, 1, 3, 4, 15, 1, "R8");
        grp(1, 0, 1, 13, 15, 16, 1, 16, 2, 0, 0, "R8");
        grp(1, 0, 0, 13, 16, 0, 0, 15, 16, 0, 0, "R8");
        grp(1, 0, 2, 13, 15, 17, 1, 17, 13, 18, 1, "R8");
        // R2: idle cycles give no output
        idle("R2");
        idle("R2");
        // R9: flush drops the group and restores identity, head continues
        grp(1, 1, 128, 1, 2, 3, 1, 4, 5, 6, 1, "R9");
        grp(1, 0, 128, 1, 10, 19, 1, 3, 19, 6, 1, "R9");

        // R5: mixed traffic, long enough to wrap the tag head
        begin
            int unsigned lcg;
            lcg = 32'h1234_5678;
            for (int i = 0; i < 300; i++) begin
                int f[10];
                for (int k = 0; k < 10; k++) begin
                    lcg = lcg * 32'd1103515245 + 32'd12345;
                    f[k] = int'(lcg >> 16);
                end
                grp((f[0] % 8) != 0, (f[1] % 29) == 0, f[2] % 4,
                    f[3] % NREG, f[4] % NREG, f[5] % NREG, (f[6] % 4) != 0,
                    (f[7] % 3 == 0) ? f[5] % NREG : f[7] % NREG, f[8] % NREG,
                    f[9] % NREG, (f[9] % 5) != 0, "R5");
            end
        end
        idle("R2");
        idle("R2");
        @(negedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule